// File: doc/BRIEF.md
# I2C Slave Configuration Register Bank

This block lets a host processor on an I2C bus read and write a small bank of 8-bit configuration registers, as a power-management controller would use to hold supply settings. SCL and SDA are oversampled with the system clock. Start and stop conditions are recognised on the synchronised copies, and only the fixed 7-bit device address is answered. The first data byte of a write sets an internal register pointer. Later bytes store to the register it points at and advance it. A read streams bytes from the pointer onwards until the host withholds its acknowledge.

The block pulls SDA low through an output enable and never drives it high. An asserted undervoltage flag returns every register to its default. So does a pushbutton input held low for longer than a parameterised number of clock cycles, which is fifteen seconds at the default clock.

Top module: `i2c_rf_top`

## Requirements
- R1: The block acknowledges only the 7-bit address 1001000b (byte 90h for write, 91h for read). For any other address it leaves SDA released and changes no register.
- R2: A start condition (SDA falling while SCL is high) is accepted at any point, including in the middle of a byte, and restarts address reception. A stop condition (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: After each byte it receives while addressed, the block holds SDA low for the whole high phase of the ninth clock.
- R4: In a write transfer, the first data byte sets the register pointer. Each later byte is stored at the pointer, and the pointer then increments. A register changes only through such a write or a default restore.
- R5: A read transfer returns the register at the pointer, MSB first. The first bit appears after the falling SCL edge that ends the address acknowledge. The pointer increments after each byte, and the next byte follows the host's acknowledge.
- R6: Register addresses at or above NREGS (8 by default) read back as 00h, and writes to them have no effect.
- R7: When the host does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start condition.
- R8: Reset, or an undervoltage input at 1, returns register i to its default value A0h + i on the next clock edge.
- R9: With PB_RESET_EN set, a pushbutton input held low for more than PB_HOLD_CYCLES consecutive clocks restores all defaults. A shorter press has no effect.
- R10: SDA is only ever pulled low through sda_oe. The enable is low out of reset and changes only after a detected SCL falling edge, a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (resolved bus) |
| uvlo_i | input | 1 | Undervoltage flag, synchronous, active high |
| pb_n_i | input | 1 | Pushbutton, synchronous, active low |
| sda_oe | output | 1 | Pull SDA low when 1 |
| regs_o | output | NREGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
The assertions assume that SCL and SDA stay stable for several system clocks between edges, so that every bus edge is seen once after synchronisation. They also assume that no other device drives SDA while the block acknowledges or sends data, and that the undervoltage and pushbutton inputs are already synchronous to clk. The bench holds each SCL quarter period for eight system clocks and models the line as a wired AND of the bench and sda_oe. It changes SDA only while SCL is low, except for deliberate starts and stops, and drives uvlo_i and pb_n_i on the falling clock edge.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [6:0]  DEV_ADDR = 7'b1001000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } st_e;

    // Events derived from the synchronised bus lines.
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] reg_default(int idx);
        return 8'hA0 + 8'(idx);
    endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync
    import i2c_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_rf_proto.sv
module i2c_rf_proto
    import i2c_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr,
    output wr_req_t           wr,
    output logic              sda_oe
);
    st_e               st;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              rnw, first, nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            ptr    <= '0;
            rnw    <= 1'b0;
            first  <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.scl_rise) begin
                case (st)
                    ST_ADDR, ST_WDATA: begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end
                    ST_RDATA: cnt  <= cnt + 4'd1;
                    ST_RACK:  nack <= ev.sda;
                    default: ;
                endcase
            end else if (ev.scl_fall) begin
                case (st)
                    ST_ADDR: begin
                        if (cnt == 4'd8) begin
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                st     <= ST_AACK;
                                sda_oe <= 1'b1;
                                rnw    <= rx_sh[0];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        cnt <= '0;
                        if (rnw) begin
                            st     <= ST_RDATA;
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            st     <= ST_WDATA;
                            sda_oe <= 1'b0;
                            first  <= 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        if (cnt == 4'd8) begin
                            st     <= ST_WACK;
                            sda_oe <= 1'b1;
                            if (first) begin
                                ptr   <= rx_sh;
                                first <= 1'b0;
                            end else begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= rx_sh;
                                ptr     <= ptr + 8'd1;
                            end
                        end
                    end
                    ST_WACK: begin
                        st     <= ST_WDATA;
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                    end
                    ST_RDATA: begin
                        if (cnt == 4'd8) begin
                            st     <= ST_RACK;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 8'd1;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                    ST_RACK: begin
                        cnt <= '0;
                        if (nack) begin
                            st <= ST_IDLE;
                        end else begin
                            st     <= ST_RDATA;
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_rf_regbank.sv
module i2c_rf_regbank
    import i2c_rf_pkg::*;
#(
    parameter int NREGS          = 8,
    parameter int PB_HOLD_CYCLES = 1_875_000_000,
    parameter bit PB_RESET_EN    = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    uvlo_i,
    input  logic                    pb_n_i,
    input  wr_req_t                 wr,
    input  logic [BYTE_W-1:0]       rd_addr,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [NREGS*BYTE_W-1:0] regs_o,
    output logic                    pb_clr
);
    localparam int CW = $clog2(PB_HOLD_CYCLES + 1);

    logic clear;

    generate
        if (PB_RESET_EN) begin : g_pb
            logic [CW-1:0] hold_cnt;
            always_ff @(posedge clk) begin
                if (rst || pb_n_i)
                    hold_cnt <= '0;
                else if (hold_cnt != CW'(PB_HOLD_CYCLES))
                    hold_cnt <= hold_cnt + CW'(1);
            end
            assign pb_clr = ~pb_n_i & (hold_cnt == CW'(PB_HOLD_CYCLES));
        end else begin : g_nopb
            assign pb_clr = 1'b0;
        end
    endgenerate

    assign clear = uvlo_i | pb_clr;

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_reg
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || clear)
                    q <= reg_default(i);
                else if (wr.en && wr.addr == 8'(i))
                    q <= wr.data;
            end
            assign regs_o[i*BYTE_W +: BYTE_W] = q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++)
            if (rd_addr == 8'(i)) rd_data = regs_o[i*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/i2c_rf_top.sv
module i2c_rf_top
    import i2c_rf_pkg::*;
#(
    parameter int NREGS          = 8,
    parameter int PB_HOLD_CYCLES = 1_875_000_000,
    parameter bit PB_RESET_EN    = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   uvlo_i,
    input  logic                   pb_n_i,
    output logic                   sda_oe,
    output logic [NREGS*8-1:0]     regs_o
);
    bus_ev_t           ev;
    wr_req_t           wr;
    logic [BYTE_W-1:0] ptr, rd_data;
    logic              pb_clr;

    i2c_rf_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_rf_proto u_proto (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data),
        .ptr(ptr), .wr(wr), .sda_oe(sda_oe)
    );

    i2c_rf_regbank #(
        .NREGS(NREGS), .PB_HOLD_CYCLES(PB_HOLD_CYCLES), .PB_RESET_EN(PB_RESET_EN)
    ) u_bank (
        .clk(clk), .rst(rst), .uvlo_i(uvlo_i), .pb_n_i(pb_n_i), .wr(wr),
        .rd_addr(ptr), .rd_data(rd_data), .regs_o(regs_o), .pb_clr(pb_clr)
    );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk
    import i2c_rf_pkg::*;
#(
    parameter int NREGS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               uvlo_i,
    input logic               sda_oe,
    input logic               scl_fall,
    input logic               start_det,
    input logic               stop_det,
    input logic               wr_en,
    input logic               pb_clr,
    input logic [NREGS*8-1:0] regs_o
);
    logic [NREGS*8-1:0] dflt;
    always_comb
        for (int i = 0; i < NREGS; i++) dflt[i*8 +: 8] = reg_default(i);

    a_r8_uvlo_defaults: assert property (@(posedge clk) disable iff (rst)
        uvlo_i |=> regs_o == dflt);

    a_r9_pb_defaults: assert property (@(posedge clk) disable iff (rst)
        pb_clr |=> regs_o == dflt);

    a_r4_write_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !uvlo_i && !pb_clr) |=> $stable(regs_o));

    a_r2_start_releases: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    a_r2_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    a_r10_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));
endmodule

bind i2c_rf_top i2c_rf_chk #(.NREGS(NREGS)) u_chk (
    .clk(clk), .rst(rst), .uvlo_i(uvlo_i), .sda_oe(sda_oe),
    .scl_fall(ev.scl_fall), .start_det(ev.start), .stop_det(ev.stop),
    .wr_en(wr.en), .pb_clr(pb_clr), .regs_o(regs_o)
);

// File: tb/i2c_rf_tb.sv
module i2c_rf_top_tb_top;
    localparam int NREGS = 8;
    localparam int HOLD  = 100;
    localparam int Q     = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic scl = 1'b1, sda_m = 1'b1, uvlo = 1'b0, pbn = 1'b1;
    logic sda_oe;
    logic [NREGS*8-1:0] regs_o;
    wire  sda_line = sda_m & ~sda_oe;

    int nchk = 0, nerr = 0;
    logic [7:0] model [NREGS];

    always #4 clk = ~clk;

    i2c_rf_top #(.NREGS(NREGS), .PB_HOLD_CYCLES(HOLD), .PB_RESET_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .uvlo_i(uvlo),
        .pb_n_i(pbn), .sda_oe(sda_oe), .regs_o(regs_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(2*Q); scl = 1'b0; wq();
    endtask

    // Sends one byte; ack is 1 only if SDA was low early and late in the ninth clock high phase.
    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(1); s1 = sda_line;
        wq(2*Q-2); s2 = sda_line; wq(1); scl = 1'b0; wq();
        ack = !s1 && !s2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
        end
        sda_m = ~mack; wq(); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        return (a < NREGS) ? model[a] : 8'h00;
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < NREGS; i++)
            check(regs_o[i*8 +: 8] == model[i], req, regs_o[i*8 +: 8], model[i]);
    endtask

    task automatic model_defaults();
        for (int i = 0; i < NREGS; i++) model[i] = 8'hA0 + 8'(i);
    endtask

    task automatic burst_write(input logic [7:0] p, input int n, input logic [7:0] seed);
        bit ack;
        bus_start();
        send_byte(8'h90, ack); check(ack, "R3 addr ack", ack, 1);
        send_byte(p, ack);     check(ack, "R3 ptr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = seed + 8'(17 * k);
            send_byte(d, ack); check(ack, "R3 data ack", ack, 1);
            if (int'(p) + k < NREGS) model[int'(p) + k] = d;
        end
        bus_stop();
        check(sda_oe == 1'b0, "R2 idle after stop", sda_oe, 0);
    endtask

    task automatic burst_read(input logic [7:0] p, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'h90, ack); send_byte(p, ack);
        bus_start();
        send_byte(8'h91, ack); check(ack, "R5 read addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(b == exp_rd(int'(p) + k), req, b, exp_rd(int'(p) + k));
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] b;
        model_defaults();
        wq(5); rst = 1'b0; wq(3);

        // R10 / R8: reset state
        check(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
        check_regs("R8 reset defaults");

        // R1: address sweep, only 1001000b acknowledged
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            check(ack == (a == 'h48), "R1 address match", ack, a == 'h48);
            bus_stop();
        end
        check_regs("R1 no register change");

        // R4: pointer then burst write over whole map
        burst_write(8'h00, NREGS, 8'h3C);
        check_regs("R4 burst write");

        // R5 / R6: sequential read running past the map
        burst_read(8'h00, NREGS + 2, "R5 R6 sequential read");

        // R6: writes beyond the map ignored, reads give 00h
        burst_write(8'h20, 2, 8'h77);
        check_regs("R6 unmapped write ignored");
        burst_read(8'h20, 2, "R6 unmapped read");

        // R4: write straddling map end
        burst_write(8'h06, 3, 8'h11);
        check_regs("R4 straddle write");
        burst_read(8'h05, 4, "R5 offset read");

        // R7: host NACK, slave stays off the line
        bus_start();
        send_byte(8'h90, ack); send_byte(8'h02, ack);
        bus_start();
        send_byte(8'h91, ack);
        recv_byte(1'b0, b);
        check(b == model[2], "R5 single read", b, model[2]);
        for (int i = 0; i < 9; i++) begin
            wq(); scl = 1'b1; wq();
            check(sda_line == 1'b1, "R7 released after nack", sda_line, 1);
            wq(); scl = 1'b0;
        end
        wq();
        bus_stop();

        // R2: start in the middle of a byte restarts address phase
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'h90, ack); check(ack, "R2 repeated start mid-byte", ack, 1);
        send_byte(8'h03, ack);
        send_byte(8'h5C, ack); model[3] = 8'h5C;
        bus_stop();
        check_regs("R2 write after restart");

        // R8: undervoltage restore
        @(negedge clk); uvlo = 1'b1; @(negedge clk); uvlo = 1'b0; wq(2);
        model_defaults();
        check_regs("R8 undervoltage defaults");

        // R9: short press ignored, long press restores
        burst_write(8'h01, 2, 8'hC3);
        @(negedge clk); pbn = 1'b0; wq(HOLD); pbn = 1'b1; wq(3);
        check_regs("R9 short press ignored");
        @(negedge clk); pbn = 1'b0; wq(HOLD + 5); pbn = 1'b1; wq(3);
        model_defaults();
        check_regs("R9 long press defaults");

        burst_read(8'h00, NREGS, "R8 readback defaults");
        check(sda_oe == 1'b0, "R10 idle release", sda_oe, 0);
        finish_run();
    end
endmodule